// File: doc/BRIEF.md
# Transmit Byte FIFO with Byte and Word Push Ports

This block sits between a register interface and a serial shifting engine on the transmit side. Software fills it through two push ports. One port takes a single byte from the low lane of a 32-bit write. The other takes a whole 32-bit word and stores its four bytes, least significant first. The FIFO keeps everything as one byte stream. The serial engine drains that stream one byte per cycle through a valid/pop pair.

A status word reports the free space in bytes in its upper half, so software can decide how much to write next. Three sticky event bits, at fixed positions that the interrupt logic decodes, flag these events:
- the buffer draining to empty,
- the buffer filling completely,
- a push that had to be dropped.

A word push is all-or-nothing. If fewer than four bytes are free, none of its bytes enter the stream. The depth is a byte-count parameter, a power of two, 64 by default.

Top module: `tx_byte_fifo_packer`

## Requirements
- R1: A byte-port push stores only `byte_wr_data[7:0]`. Bits 31:8 never reach the stream.
- R2: A word-port push stores four bytes in stream order: bits 7:0, then 15:8, then 23:16, then 31:24.
- R3: `out_valid` is high exactly when the FIFO holds data, and `out_byte` shows the oldest byte. Each cycle with `pop_req` and `out_valid` both high removes one byte. Bytes leave in the order they were stored.
- R4: `status_word[31:16]` equals DEPTH minus the number of bytes held, and `status_word[15:0]` is zero. After reset the free count is DEPTH.
- R5: A word push is accepted only when at least four bytes are free. Otherwise the whole word is dropped, the stored contents and free count stay unchanged, and overrun (`irq_flags[11]`) is set.
- R6: A byte push when no byte is free is dropped and sets overrun (`irq_flags[11]`).
- R7: When both ports push in the same cycle, the byte enters the stream before the word's four bytes. The byte is checked against free space first, and the word is checked against the room left after it.
- R8: Empty (`irq_flags[9]`) latches on the cycle the held count goes from non-zero to zero. It is not set by reset. `lvl_empty` is the live level of "count is zero".
- R9: Full (`irq_flags[10]`) latches on the cycle the held count reaches DEPTH. `lvl_full` is the live level.
- R10: Flags stay set until a 1 is written to the matching bit of `flag_clr`. A new event in the same cycle as its clear leaves the flag set. All other bits of `irq_flags` read zero.
- R11: In a cycle with both a push and a pop, room for the push is judged from the count held before that cycle. The pop does not make room for a same-cycle push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_wr_en | input | 1 | Push one byte this cycle |
| byte_wr_data | input | 32 | Write data for the byte port; only bits 7:0 are used |
| word_wr_en | input | 1 | Push four bytes this cycle |
| word_wr_data | input | 32 | Word for the word port, low byte first in the stream |
| pop_req | input | 1 | Serial engine takes the head byte |
| out_valid | output | 1 | FIFO holds at least one byte |
| out_byte | output | 8 | Oldest stored byte |
| status_word | output | 32 | Free bytes in bits 31:16, zero below |
| lvl_empty | output | 1 | Live empty level |
| lvl_full | output | 1 | Live full level |
| flag_clr | input | 16 | Write-one-to-clear for the bits of `irq_flags` |
| irq_flags | output | 16 | Sticky events: bit 9 empty, bit 10 full, bit 11 overrun |

## Verification
The bench goes after the all-or-nothing rule by offering a word when two or three bytes are free. A design that stored a partial word would lose the free count and put stray bytes into the stream. A simultaneous byte-and-word push checks the stream order and catches a design that put the word ahead of the byte. A push in the same cycle as a pop on a full FIFO must still be dropped; a design that credited the pop first would accept it and shift every later byte. Other cases:
- The empty flag is checked after reset. It must stay clear there, because only a transition may set it.
- A clear that coincides with a new overrun must leave the flag set. A design that gave the clear priority would lose the event.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned MAX_WR     = WORD_BYTES + 1;

    // event bit positions decoded by the interrupt logic
    localparam int unsigned FLG_EMPTY = 9;
    localparam int unsigned FLG_FULL  = 10;
    localparam int unsigned FLG_OVR   = 11;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic ovr;
        logic full;
        logic empty;
    } flag_set_t;

    // bytes to be written in one cycle, data[0] goes in first
    typedef struct packed {
        logic [2:0]                 n;
        byte_t [MAX_WR-1:0]         data;
    } wr_bundle_t;

    function automatic logic [31:0] pack_status(input logic [15:0] free_b);
        return {free_b, 16'h0000};
    endfunction

    function automatic logic [15:0] place_flags(input flag_set_t f);
        logic [15:0] v;
        v            = '0;
        v[FLG_EMPTY] = f.empty;
        v[FLG_FULL]  = f.full;
        v[FLG_OVR]   = f.ovr;
        return v;
    endfunction

    function automatic flag_set_t pick_flags(input logic [15:0] v);
        flag_set_t f;
        f.empty = v[FLG_EMPTY];
        f.full  = v[FLG_FULL];
        f.ovr   = v[FLG_OVR];
        return f;
    endfunction

endpackage

// File: rtl/tfp_admit.sv
module tfp_admit
    import tfp_pkg::*;
#(
    parameter int unsigned CW = 7
) (
    input  logic          byte_en,
    input  byte_t         byte_data,
    input  logic          word_en,
    input  logic [31:0]   word_data,
    input  logic [CW-1:0] free_b,
    output wr_bundle_t    bundle,
    output logic          drop
);

    logic          byte_ok;
    logic          word_ok;
    logic [CW-1:0] room_left;

    always_comb begin
        byte_ok   = byte_en && (free_b != '0);
        room_left = free_b - (byte_ok ? CW'(1) : CW'(0));
        word_ok   = word_en && (room_left >= CW'(WORD_BYTES));
        drop      = (byte_en && !byte_ok) || (word_en && !word_ok);

        bundle.n    = (byte_ok ? 3'd1 : 3'd0) + (word_ok ? 3'(WORD_BYTES) : 3'd0);
        bundle.data = '0;
        if (byte_ok) begin
            bundle.data[0] = byte_data;
        end
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (byte_ok) begin
                bundle.data[b+1] = word_data[8*b +: 8];
            end else begin
                bundle.data[b] = word_data[8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/tfp_store.sv
module tfp_store
    import tfp_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 6,
    parameter int unsigned CW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_bundle_t    bundle,
    input  logic          pop,
    output byte_t         head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt
);

    byte_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          pop_do;

    assign pop_do    = pop && (count != '0);
    assign count_nxt = count + CW'(bundle.n) - (pop_do ? CW'(1) : CW'(0));
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        for (int k = 0; k < MAX_WR; k++) begin
            if (3'(k) < bundle.n) begin
                mem[wr_ptr + AW'(k)] <= bundle.data[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(bundle.n);
            rd_ptr <= rd_ptr + (pop_do ? AW'(1) : AW'(0));
            count  <= count_nxt;
        end
    end

    // R4: the held count never exceeds the depth
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3: a lone pop removes exactly one byte
    p_pop_one_r3: assert property (@(posedge clk) disable iff (rst)
        (pop && count != '0 && bundle.n == 3'd0) |=> (count == $past(count) - CW'(1)));

endmodule

// File: rtl/tfp_flags.sv
module tfp_flags
    import tfp_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] count_nxt,
    input  logic          drop,
    input  flag_set_t     clr,
    output flag_set_t     flags
);

    flag_set_t ev;

    always_comb begin
        ev.empty = (count != '0) && (count_nxt == '0);
        ev.full  = (count != CW'(DEPTH)) && (count_nxt == CW'(DEPTH));
        ev.ovr   = drop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= ev | (flags & ~clr);
        end
    end

    // R10: overrun holds until cleared
    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flags.ovr && !clr.ovr) |=> flags.ovr);

    // R8: empty only rises together with an empty buffer
    p_empty_edge_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.empty) |-> (count == '0));

    // R9: full only rises together with a full buffer
    p_full_edge_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.full) |-> (count == CW'(DEPTH)));

endmodule

// File: rtl/tx_byte_fifo_packer.sv
module tx_byte_fifo_packer
    import tfp_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_wr_en,
    input  logic [31:0] byte_wr_data,
    input  logic        word_wr_en,
    input  logic [31:0] word_wr_data,
    input  logic        pop_req,
    output logic        out_valid,
    output logic [7:0]  out_byte,
    output logic [31:0] status_word,
    output logic        lvl_empty,
    output logic        lvl_full,
    input  logic [15:0] flag_clr,
    output logic [15:0] irq_flags
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    wr_bundle_t    bundle;
    logic          drop;
    logic [CW-1:0] count;
    logic [CW-1:0] count_nxt;
    logic [CW-1:0] free_b;
    flag_set_t     flags;
    flag_set_t     clr;
    byte_t         head;
    logic          unused_bits;

    assign unused_bits = ^{byte_wr_data[31:8], flag_clr};
    assign free_b      = CW'(DEPTH) - count;
    assign clr         = pick_flags(flag_clr);

    tfp_admit #(.CW(CW)) u_admit (
        .byte_en   (byte_wr_en),
        .byte_data (byte_wr_data[7:0]),
        .word_en   (word_wr_en),
        .word_data (word_wr_data),
        .free_b    (free_b),
        .bundle    (bundle),
        .drop      (drop)
    );

    tfp_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .bundle    (bundle),
        .pop       (pop_req),
        .head      (head),
        .count     (count),
        .count_nxt (count_nxt)
    );

    tfp_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .count     (count),
        .count_nxt (count_nxt),
        .drop      (drop),
        .clr       (clr),
        .flags     (flags)
    );

    assign out_valid   = (count != '0);
    assign out_byte    = head;
    assign lvl_empty   = (count == '0);
    assign lvl_full    = (count == CW'(DEPTH));
    assign status_word = pack_status(16'(free_b));
    assign irq_flags   = place_flags(flags);

    // R5: a word that does not fit leaves the free count alone and flags overrun
    p_word_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (word_wr_en && !byte_wr_en && !(pop_req && out_valid) && status_word[31:16] < 16'd4)
        |=> (irq_flags[FLG_OVR] && status_word[31:16] == $past(status_word[31:16])));

    // R6: a byte offered to a full buffer flags overrun
    p_byte_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_wr_en && lvl_full) |=> irq_flags[FLG_OVR]);

endmodule

// File: tb/tb_tx_byte_fifo_packer.sv
`timescale 1ns/1ps
module tb_tx_byte_fifo_packer;

    localparam int unsigned DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        byte_wr_en;
    logic [31:0] byte_wr_data;
    logic        word_wr_en;
    logic [31:0] word_wr_data;
    logic        pop_req;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic [31:0] status_word;
    logic        lvl_empty;
    logic        lvl_full;
    logic [15:0] flag_clr;
    logic [15:0] irq_flags;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    tx_byte_fifo_packer #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .byte_wr_en(byte_wr_en), .byte_wr_data(byte_wr_data),
        .word_wr_en(word_wr_en), .word_wr_data(word_wr_data),
        .pop_req(pop_req), .out_valid(out_valid), .out_byte(out_byte),
        .status_word(status_word), .lvl_empty(lvl_empty), .lvl_full(lvl_full),
        .flag_clr(flag_clr), .irq_flags(irq_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every popped byte must match the scoreboard head (R1 R2 R3 R7)
    always @(negedge clk) begin
        if (!rst && pop_req && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected byte", {24'h0, out_byte}, 32'hxxxx_xxxx);
            end else begin
                check("R3 stream order", {24'h0, out_byte}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    // driver: one cycle of stimulus, scoreboard updated by the requirements
    task automatic drive(input logic be, input logic [31:0] bd, input logic we,
                         input logic [31:0] wd, input logic pp, input logic [15:0] clr);
        int free_b;
        int room;
        @(posedge clk); #1;
        free_b = DEPTH - exp_q.size();
        room   = free_b;
        if (be && free_b >= 1) begin
            exp_q.push_back(bd[7:0]);
            room = free_b - 1;
        end
        if (we && room >= 4) begin
            for (int b = 0; b < 4; b++) exp_q.push_back(wd[8*b +: 8]);
        end
        byte_wr_en = be; byte_wr_data = bd;
        word_wr_en = we; word_wr_data = wd;
        pop_req = pp; flag_clr = clr;
        @(posedge clk); #1;
        byte_wr_en = 1'b0; word_wr_en = 1'b0; pop_req = 1'b0; flag_clr = '0;
    endtask

    task automatic drain(input int n);
        @(posedge clk); #1;
        pop_req = 1'b1;
        repeat (n) @(posedge clk);
        #1 pop_req = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; byte_wr_en = 0; byte_wr_data = 0; word_wr_en = 0; word_wr_data = 0;
        pop_req = 0; flag_clr = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R3 reset valid", {31'h0, out_valid}, 32'h0);
        check("R4 reset free", status_word, 32'h0040_0000);
        check("R8 no empty flag at reset", {16'h0, irq_flags}, 32'h0);
        check("R8 reset level", {31'h0, lvl_empty}, 32'h1);

        // R1: only low lane
        drive(1, 32'hABCDEF5A, 0, 0, 0, 0);
        @(negedge clk);
        check("R4 free after byte", status_word, 32'h003F_0000);
        check("R3 valid", {31'h0, out_valid}, 32'h1);
        drain(1);
        @(negedge clk);
        check("R8 empty latched", {16'h0, irq_flags}, 32'h0000_0200);
        drive(0, 0, 0, 0, 0, 16'h0200);
        @(negedge clk);
        check("R10 clear empty", {16'h0, irq_flags}, 32'h0);

        // R2: word order
        drive(0, 0, 1, 32'h44332211, 0, 0);
        @(negedge clk);
        check("R4 free after word", status_word, 32'h003C_0000);
        drain(4);

        // R7: byte ahead of word
        drive(1, 32'h000000A5, 1, 32'hD4C3B2A1, 0, 0);
        @(negedge clk);
        check("R7 both accepted", status_word, 32'h003B_0000);
        drain(5);
        drive(0, 0, 0, 0, 0, 16'hFFFF);

        // R9: fill with words
        for (int i = 0; i < DEPTH / 4; i++) drive(0, 0, 1, 32'h10203040 + i * 32'h01010101, 0, 0);
        @(negedge clk);
        check("R9 full level", {31'h0, lvl_full}, 32'h1);
        check("R9 full flag", {16'h0, irq_flags}, 32'h0000_0400);
        check("R4 free at full", status_word, 32'h0);

        // R6: byte into full buffer
        drive(1, 32'h000000EE, 0, 0, 0, 0);
        @(negedge clk);
        check("R6 overrun on byte", {16'h0, irq_flags & 16'h0800}, 32'h0000_0800);
        check("R6 free unchanged", status_word, 32'h0);
        drive(0, 0, 0, 0, 0, 16'h0800);
        @(negedge clk);
        check("R10 clear overrun only", {16'h0, irq_flags}, 32'h0000_0400);

        // R5: word with three free
        drain(3);
        drive(0, 0, 1, 32'h99887766, 0, 0);
        @(negedge clk);
        check("R5 overrun on word", {16'h0, irq_flags & 16'h0800}, 32'h0000_0800);
        check("R5 free unchanged", status_word, 32'h0003_0000);
        drive(0, 0, 0, 0, 0, 16'h0800);
        for (int i = 0; i < 3; i++) drive(1, 32'h000000C0 + i, 0, 0, 0, 0);
        @(negedge clk);
        check("R6 bytes fill to full", status_word, 32'h0);

        // R10: new event wins over its clear
        drive(1, 32'h000000DD, 0, 0, 0, 16'h0800);
        @(negedge clk);
        check("R10 set beats clear", {16'h0, irq_flags & 16'h0800}, 32'h0000_0800);

        // R11: pop does not make room for a same-cycle push
        drive(1, 32'h000000BB, 0, 0, 1, 16'h0800);
        @(negedge clk);
        check("R11 push dropped with pop", status_word, 32'h0001_0000);
        check("R11 overrun", {16'h0, irq_flags & 16'h0800}, 32'h0000_0800);

        drain(DEPTH - 1);
        @(negedge clk);
        check("R8 empty after drain", {16'h0, irq_flags & 16'h0200}, 32'h0000_0200);
        check("R4 free after drain", status_word, 32'h0040_0000);

        // R11: push and pop balance
        drive(1, 32'h00000077, 0, 0, 0, 0);
        drive(1, 32'h00000088, 0, 0, 1, 0);
        @(negedge clk);
        check("R11 count held", status_word, 32'h003F_0000);
        drain(1);
        @(negedge clk);
        check("R3 all bytes seen", exp_q.size(), 32'h0);
        check("R3 valid low at end", {31'h0, out_valid}, 32'h0);
        finish_run();
    end

endmodule